// File: doc/BRIEF.md
# Queue Interrupt Condition Selector

This block turns the live status of 32 hardware queues into one interrupt line. Each queue presents four level flags: empty, nearly empty, nearly full and full. A 3-bit source code per queue selects one of eight conditions. The choices are the four flags and their four inverses. When the selected condition goes from false to true, a pending bit for that queue is latched. Software clears a pending bit by writing a one to it. A per-queue enable mask then gates the pending bits onto a single registered interrupt output.

Software reaches the block through a word-addressed bus. The bus has a write strobe and a combinational read path. Words 0 to 3 hold the source codes, one 4-bit nibble per queue. Word 4 is the enable mask and word 5 is the pending register. Words 6 and 7 are unused. The block does not store queue contents or compute the status flags. Dispatching the interrupt to handlers is also left to other logic.

Top module: `qirq_selector`

## Requirements
- R1: After reset every source code, enable bit and pending bit reads zero and `irq_out` is low. A condition that is already true while reset is held does not set a pending bit once reset is released.
- R2: Source code values select the condition as follows: 0 empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full, 7 not full. No other flag has any effect on that queue.
- R3: A pending bit sets in the clock edge that first samples its selected condition true after it was false. Holding the condition true does not set the bit again once it has been cleared. Pending bits never set without such a rise.
- R4: Writing word 5 clears every pending bit whose data bit is 1. Bits written as 0 keep their value.
- R5: If a rise of the selected condition and a write-1 clear of the same bit land in the same cycle, the bit ends set.
- R6: Word 4 holds the enable mask, with bit n belonging to queue n. `irq_out` equals the OR over all queues of pending AND enable, sampled one clock later.
- R7: Writing a queue's source code leaves its pending bit unchanged. A condition that is true at once under the new code does not count as a rise.
- R8: Queue q's code sits in word q/8, bits 4*(q%8) to 4*(q%8)+2. The fourth bit of each nibble, and the whole of words 6 and 7, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | NUM_Q | Per-queue empty flag |
| q_near_empty | input | NUM_Q | Per-queue nearly-empty flag |
| q_near_full | input | NUM_Q | Per-queue nearly-full flag |
| q_full | input | NUM_Q | Per-queue full flag |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong source mapping or a bad edge register shows in the pending word. That word becomes readable one cycle after the flag changes. A stale enable mask or a broken clear path shows on `irq_out` within two cycles of the bus write. The sweep toggles a flag that was not selected before it toggles the selected one. This catches swapped codes, which would look correct if all flags moved together.

// File: rtl/qirq_pkg.sv
`timescale 1ns/1ps
package qirq_pkg;
  localparam int WORD_W     = 32;
  localparam int NIB_W      = 4;
  localparam int SRC_W      = 3;
  localparam int Q_PER_WORD = WORD_W / NIB_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_EMPTY          = 3'd0,
    SRC_NEAR_EMPTY     = 3'd1,
    SRC_NEAR_FULL      = 3'd2,
    SRC_FULL           = 3'd3,
    SRC_NOT_EMPTY      = 3'd4,
    SRC_NOT_NEAR_EMPTY = 3'd5,
    SRC_NOT_NEAR_FULL  = 3'd6,
    SRC_NOT_FULL       = 3'd7
  } src_code_e;

  typedef struct packed {
    logic full;
    logic near_full;
    logic near_empty;
    logic empty;
  } qflags_t;

  // Low two code bits pick the flag, the top bit inverts it.
  function automatic logic sel_cond(input logic [SRC_W-1:0] code, input qflags_t f);
    logic raw;
    case (code[1:0])
      2'd0:    raw = f.empty;
      2'd1:    raw = f.near_empty;
      2'd2:    raw = f.near_full;
      default: raw = f.full;
    endcase
    return raw ^ code[2];
  endfunction

  function automatic logic [NIB_W-1:0] to_nibble(input logic [SRC_W-1:0] code);
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/qirq_cond_sel.sv
`timescale 1ns/1ps
module qirq_cond_sel
  import qirq_pkg::*;
#(
  parameter int NUM_Q = 32
) (
  input  logic [NUM_Q-1:0]       st_empty,
  input  logic [NUM_Q-1:0]       st_near_empty,
  input  logic [NUM_Q-1:0]       st_near_full,
  input  logic [NUM_Q-1:0]       st_full,
  input  logic [NUM_Q*SRC_W-1:0] src_flat,
  output logic [NUM_Q-1:0]       cond
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    qflags_t fl;
    assign fl.empty      = st_empty[i];
    assign fl.near_empty = st_near_empty[i];
    assign fl.near_full  = st_near_full[i];
    assign fl.full       = st_full[i];
    assign cond[i]       = sel_cond(src_flat[i*SRC_W +: SRC_W], fl);
  end
endmodule

// File: rtl/qirq_cfg_regs.sv
`timescale 1ns/1ps
module qirq_cfg_regs
  import qirq_pkg::*;
#(
  parameter int NUM_Q  = 32,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [NUM_Q*SRC_W-1:0]  src_flat,
  output logic [NUM_Q*NIB_W-1:0]  src_words,
  output logic [NUM_Q-1:0]        en_q,
  output logic [NUM_Q-1:0]        src_chg_q
);
  localparam int SRC_WORDS = NUM_Q / Q_PER_WORD;
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(SRC_WORDS);

  logic [SRC_W-1:0] src_q [NUM_Q];

  for (genvar i = 0; i < NUM_Q; i++) begin : g_src
    localparam int W = i / Q_PER_WORD;
    localparam int L = i % Q_PER_WORD;
    logic             hit;
    logic [SRC_W-1:0] nxt;
    assign hit = wr_en && (wr_addr == ADDR_W'(W));
    assign nxt = wr_data[L*NIB_W +: SRC_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i]     <= '0;
        src_chg_q[i] <= 1'b0;
      end else begin
        src_chg_q[i] <= hit && (nxt != src_q[i]);
        if (hit) src_q[i] <= nxt;
      end
    end

    assign src_flat[i*SRC_W +: SRC_W]  = src_q[i];
    assign src_words[i*NIB_W +: NIB_W] = to_nibble(src_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        en_q <= '0;
    else if (wr_en && wr_addr == EN_A) en_q <= wr_data[NUM_Q-1:0];
  end

  // R7: a source-change marker only follows a bus write
  p_chg_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_chg_q != '0) |-> $past(wr_en));
endmodule

// File: rtl/qirq_pending.sv
`timescale 1ns/1ps
module qirq_pending #(
  parameter int NUM_Q = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] cond,
  input  logic [NUM_Q-1:0] src_chg,
  input  logic [NUM_Q-1:0] clr_mask,
  output logic [NUM_Q-1:0] pend_q,
  output logic [NUM_Q-1:0] edge_evt
);
  logic [NUM_Q-1:0] cond_q;

  // Reset to ones: a condition already true at reset is not a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '1;
    else        cond_q <= cond;
  end

  assign edge_evt = cond & ~cond_q & ~src_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | edge_evt;
  end

  p_set_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((pend_q & $past(edge_evt)) == $past(edge_evt)));

  p_no_spont_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_evt)) == '0));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~edge_evt) != '0) |=> ((pend_q & $past(clr_mask & ~edge_evt)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & edge_evt) != '0) |=>
      ((pend_q & $past(clr_mask & edge_evt)) == $past(clr_mask & edge_evt)));
endmodule

// File: rtl/qirq_selector.sv
`timescale 1ns/1ps
module qirq_selector
  import qirq_pkg::*;
#(
  parameter int NUM_Q  = 32,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_Q-1:0]   q_empty,
  input  logic [NUM_Q-1:0]   q_near_empty,
  input  logic [NUM_Q-1:0]   q_near_full,
  input  logic [NUM_Q-1:0]   q_full,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int SRC_WORDS = NUM_Q / Q_PER_WORD;
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(SRC_WORDS);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(SRC_WORDS + 1);

  logic [NUM_Q*SRC_W-1:0] src_flat;
  logic [NUM_Q*NIB_W-1:0] src_words;
  logic [NUM_Q-1:0]       en_q, src_chg_q, cond, pend_q, edge_evt, clr_mask;
  logic                   irq_q;

  qirq_cfg_regs #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .src_flat(src_flat), .src_words(src_words),
    .en_q(en_q), .src_chg_q(src_chg_q));

  qirq_cond_sel #(.NUM_Q(NUM_Q)) i_cond (
    .st_empty(q_empty), .st_near_empty(q_near_empty),
    .st_near_full(q_near_full), .st_full(q_full),
    .src_flat(src_flat), .cond(cond));

  assign clr_mask = (bus_we && bus_addr == PEND_A) ? bus_wdata[NUM_Q-1:0] : '0;

  qirq_pending #(.NUM_Q(NUM_Q)) i_pend (
    .clk(clk), .rst_n(rst_n), .cond(cond), .src_chg(src_chg_q),
    .clr_mask(clr_mask), .pend_q(pend_q), .edge_evt(edge_evt));

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < SRC_WORDS)
      bus_rdata = src_words[int'(bus_addr)*WORD_W +: WORD_W];
    else if (bus_addr == EN_A)
      bus_rdata[NUM_Q-1:0] = en_q;
    else if (bus_addr == PEND_A)
      bus_rdata[NUM_Q-1:0] = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_q & en_q);
  end
  assign irq_out = irq_q;

  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(pend_q & en_q))));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_out);
endmodule

// File: tb/test_qirq_selector.sv
`timescale 1ns/1ps
module test_qirq_selector;
  localparam int NQ = 32;
  localparam int AW = 3;
  localparam logic [AW-1:0] EN_A = 3'd4, PEND_A = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NQ-1:0] fe = '0, fne = '0, fnf = '0, ff = '0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [2:0] sh_src [NQ];

  always #2.5 clk = ~clk;

  qirq_selector #(.NUM_Q(NQ), .ADDR_W(AW)) i_qirq_selector (
    .clk(clk), .rst_n(rst_n), .q_empty(fe), .q_near_empty(fne),
    .q_near_full(fnf), .q_full(ff), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  function automatic logic [31:0] src_word(input int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 8; l++) r[l*4 +: 4] = {1'b0, sh_src[w*8+l]};
    return r;
  endfunction

  task automatic set_flag(input int q, input int idx, input logic v);
    case (idx)
      0: fe[q] = v;
      1: fne[q] = v;
      2: fnf[q] = v;
      default: ff[q] = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int q = 0; q < NQ; q++) sh_src[q] = 3'd0;
    fe = '1;                         // empty true through reset (code 0)
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    fe = '0; tick(); tick();
    rd(PEND_A, v); chk("R1 no set from falling", v, 32'h0);

    // R8 reserved nibble bit and unused words
    wr(3'd0, 32'hFFFF_FFFF);
    for (int q = 0; q < 8; q++) sh_src[q] = 3'd7;
    rd(3'd0, v); chk("R8 reserved bit zero", v, 32'h7777_7777);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hA5A5_A5A5);
    rd(3'd6, v); chk("R8 word 6 reads zero", v, 32'h0);
    rd(3'd7, v); chk("R8 word 7 reads zero", v, 32'h0);
    rd(EN_A, v); chk("R8 enable untouched", v, 32'h0);
    rd(PEND_A, v); chk("R8 pending untouched", v, 32'h0);
    wr(3'd0, 32'h0);
    for (int q = 0; q < 8; q++) sh_src[q] = 3'd0;
    fe = '0; fne = '0; fnf = '0; ff = '0;
    tick(); tick();

    // R2/R3/R4 sweep over every queue and code
    for (int q = 0; q < NQ; q++) begin
      for (int c = 0; c < 8; c++) begin
        logic base;
        base = (c >= 4);
        sh_src[q] = 3'(c);
        wr(3'(q/8), src_word(q/8));
        rd(3'(q/8), v); chk("R8 source word layout", v, src_word(q/8));
        for (int k = 0; k < 4; k++) set_flag(q, k, base);
        tick(); tick();
        wr(PEND_A, 32'hFFFF_FFFF);
        tick();
        rd(PEND_A, v); chk("R4 clear all", v, 32'h0);
        set_flag(q, (c + 1) % 4, ~base);
        tick();
        rd(PEND_A, v); chk("R2 unselected flag ignored", v, 32'h0);
        set_flag(q, c % 4, ~base);
        tick();
        rd(PEND_A, v); chk("R2 selected condition sets", v, 32'h1 << q);
        wr(PEND_A, 32'h1 << q);
        rd(PEND_A, v); chk("R4 write-1 clear", v, 32'h0);
        tick(); tick();
        rd(PEND_A, v); chk("R3 held condition no reset", v, 32'h0);
      end
    end

    // R6 enable and registered interrupt
    for (int w = 0; w < 4; w++) wr(3'(w), 32'h0);
    for (int q = 0; q < NQ; q++) sh_src[q] = 3'd0;
    fe = '0; fne = '0; fnf = '0; ff = '0;
    tick(); tick();
    wr(PEND_A, 32'hFFFF_FFFF);
    fe = '1; tick();
    rd(PEND_A, v); chk("R3 all queues rise", v, 32'hFFFF_FFFF);
    tick();
    chk("R6 no enable no irq", {31'b0, irq}, 32'h0);
    for (int k = 0; k < NQ; k++) begin
      wr(EN_A, 32'h1 << k);
      rd(EN_A, v); chk("R6 enable readback", v, 32'h1 << k);
      chk("R6 irq one cycle late", {31'b0, irq}, 32'h0);
      tick();
      chk("R6 irq asserted", {31'b0, irq}, 32'h1);
      wr(PEND_A, 32'h1 << k);
      chk("R6 irq held one cycle", {31'b0, irq}, 32'h1);
      tick();
      chk("R6 irq drops", {31'b0, irq}, 32'h0);
      rd(PEND_A, v); chk("R4 single bit clear", v, 32'hFFFF_FFFF << (k + 1));
    end
    wr(EN_A, 32'h0);

    // R5 set wins over simultaneous clear
    fe[5] = 1'b0; fe[6] = 1'b0; tick();
    fe[5] = 1'b1; fe[6] = 1'b1; tick();
    fe[5] = 1'b0; tick();
    rd(PEND_A, v); chk("R3 both pending", v & 32'h60, 32'h60);
    @(negedge clk);
    fe[5] = 1'b1;
    bus_we = 1'b1; bus_addr = PEND_A; bus_wdata = 32'h60;
    @(negedge clk);
    bus_we = 1'b0;
    rd(PEND_A, v); chk("R5 set wins", v & 32'h60, 32'h20);

    // R7 source write keeps pending and is not a rise
    fe[9] = 1'b0; ff[9] = 1'b1; tick();
    fe[9] = 1'b1; tick();
    rd(PEND_A, v); chk("R3 queue 9 set", (v >> 9) & 1, 32'h1);
    sh_src[9] = 3'd3;
    wr(3'd1, src_word(1));
    rd(PEND_A, v); chk("R7 pending kept", (v >> 9) & 1, 32'h1);
    wr(PEND_A, 32'h1 << 9);
    tick(); tick();
    rd(PEND_A, v); chk("R7 code change not a rise", (v >> 9) & 1, 32'h0);
    ff[9] = 1'b0; tick();
    ff[9] = 1'b1; tick();
    rd(PEND_A, v); chk("R2 new code full rises", (v >> 9) & 1, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule